// File: doc/BRIEF.md
# Divide-by-Three Clock Generator with Even Duty Cycle

This block takes a free-running input clock and produces a clock at exactly one third of its frequency. The output is high for half the time. A plain modulo-3 counter can only hold its output high for one or two whole input periods out of three. To get an even duty cycle, this block also uses the falling input edge. A two-bit counter advances on every rising edge. One of its bits is copied by a flop clocked on the falling edge. The output is the OR of the counter bit and that delayed copy, so it stays high for one and a half input periods and then low for one and a half.

Two further outputs are provided. One is the raw counter bit, which has a duty cycle of one third. The other comes from a spare flop that divides the input by two. Each output rise lines up with a rising input edge. Each output fall lines up with a falling input edge. Because the ratio is odd, the output edges therefore alternate between the two input edge polarities. The block does not drift over time: it gives exactly one output period for every three input periods.

Top module: `div3_clock_divider`

## Requirements
- R1: While `rst_n` is low at a rising input edge, every flop clears. From the second input period of reset onward, all three outputs are low.
- R2: The counter steps through the codes 0, 1, 2 and back to 0, advancing once per rising input edge. If the counter ever holds the illegal code 3, it returns to 0 on the next rising edge.
- R3: `div3_raw` is bit 0 of the counter. It is high for exactly one input period out of every three, and it changes only just after a rising input edge.
- R4: `div3_out` rises only just after a rising input edge. Once the first full output period is complete, every high interval lasts exactly three input half-periods.
- R5: `div3_out` falls only just after a falling input edge. Once the first full output period is complete, every low interval lasts exactly three input half-periods.
- R6: Release `rst_n` between a falling edge and the following rising edge. `div3_out` and `div3_raw` then go high just after the first rising input edge that follows.
- R7: Over any run that starts at reset release, `div3_out` has exactly one rising edge per three input periods, counting from the first rising edge after release.
- R8: `div2_out` toggles on every rising input edge while out of reset. It goes high at the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; both edges are used |
| rst_n | input | 1 | Active-low reset, sampled on the clock edges |
| div3_out | output | 1 | Input clock divided by three, 50% duty cycle |
| div3_raw | output | 1 | Counter bit 0; divide-by-three with one-third duty cycle |
| div2_out | output | 1 | Input clock divided by two |

## Verification
The assertions check three things on every clock edge:
- the counter visits its states in the required order, and recovers from the illegal code;
- the falling-edge copy is high only while the counter sits in code 2;
- the raw and divide-by-two taps keep their fixed patterns at the rising edges.

Some behaviour can only be shown by the bench's scenarios. These are the exact three-half-period widths of the high and low intervals, which input edge each output edge lands on, the latency after reset release, and the edge count over long runs. The bench therefore samples after every input edge across reset pulses of random length and runs of random length.

// File: rtl/div3_pkg.sv
// Shared definitions for the divide-by-three clock generator.
// Assumes a two-bit modulo-3 counter whose code 3 is never entered in normal use.
package div3_pkg;
    localparam int CNT_W = 2;

    typedef enum logic [CNT_W-1:0] {
        CNT_S0  = 2'b00,
        CNT_S1  = 2'b01,
        CNT_S2  = 2'b10,
        CNT_BAD = 2'b11
    } cnt_state_t;

    // Next code for the modulo-3 sequence; the illegal code falls back to zero.
    function automatic cnt_state_t cnt_next(input cnt_state_t cur);
        case (cur)
            CNT_S0:  return CNT_S1;
            CNT_S1:  return CNT_S2;
            default: return CNT_S0;
        endcase
    endfunction
endpackage

// File: rtl/div3_mod3_counter.sv
// Modulo-3 counter clocked on the rising input edge.
// Assumes rst_n is synchronous and active low; code 3 self-clears.
module div3_mod3_counter
    import div3_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output cnt_state_t state
);
    cnt_state_t state_q;

    // Advance the count once per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_S0;
        else        state_q <= cnt_next(state_q);
    end

    assign state = state_q;

    // R2: order of the sequence, and recovery from the illegal code
    assert_seq_s0_R2:  assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_S0) |=> (state_q == CNT_S1));
    assert_seq_s1_R2:  assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_S1) |=> (state_q == CNT_S2));
    assert_seq_s2_R2:  assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_S2) |=> (state_q == CNT_S0));
    assert_bad_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_BAD) |=> (state_q == CNT_S0));
endmodule

// File: rtl/div3_neg_retime.sv
// Copies one bit onto the falling input edge, delaying it by half a period.
// Assumes the input bit changes only after rising edges; rst_n is sampled on the falling edge.
module div3_neg_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic q_r;

    // Capture on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= d;
    end

    assign q = q_r;
endmodule

// File: rtl/div3_half_tap.sv
// Spare flop that gives clk/2, or ties off when disabled by parameter.
// Assumes a synchronous active-low reset.
module div3_half_tap #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tap
);
    generate
        if (ENABLE) begin : g_on
            logic tog_q;

            // Toggle on every rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) tog_q <= 1'b0;
                else        tog_q <= ~tog_q;
            end

            assign tap = tog_q;

            // R8: the tap changes at every rising edge once out of reset
            assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (tog_q != $past(tog_q)));
        end else begin : g_off
            assign tap = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/div3_clock_divider.sv
// Top level: divides clk_in by three with an even duty cycle.
// The counter's bit 0 is ORed with its falling-edge copy, so the output stays high
// for three half-periods. Assumes clk_in runs freely and rst_n is synchronous, active low.
module div3_clock_divider
    import div3_pkg::*;
#(
    parameter bit HALF_TAP_EN = 1'b1
) (
    input  logic clk_in,
    input  logic rst_n,
    output logic div3_out,
    output logic div3_raw,
    output logic div2_out
);
    cnt_state_t cnt;
    logic       tap_bit;
    logic       tap_late;

    div3_mod3_counter u_cnt (
        .clk   (clk_in),
        .rst_n (rst_n),
        .state (cnt)
    );

    // Take the low counter bit as the one-third duty tap.
    always_comb tap_bit = cnt[0];

    div3_neg_retime u_late (
        .clk   (clk_in),
        .rst_n (rst_n),
        .d     (tap_bit),
        .q     (tap_late)
    );

    div3_half_tap #(.ENABLE(HALF_TAP_EN)) u_half (
        .clk   (clk_in),
        .rst_n (rst_n),
        .tap   (div2_out)
    );

    // Merge the tap with its late copy to stretch the high phase.
    always_comb begin
        div3_raw = tap_bit;
        div3_out = tap_bit | tap_late;
    end

    // R3: the raw tap is high for one rising-edge period only
    assert_raw_single_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        div3_raw |=> !div3_raw);
    // R5: the late copy is high only while the counter sits in code 2
    assert_late_align_R5: assert property (@(negedge clk_in) disable iff (!rst_n)
        tap_late |-> (cnt == CNT_S2));
    // R4: sampled at rising edges the output repeats high, low, low
    assert_out_pattern_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        div3_out |=> !div3_out ##1 !div3_out);
    // R1: with reset held for a full period, everything reads low
    assert_reset_low_R1: assert property (@(posedge clk_in)
        (!rst_n && $past(!rst_n)) |-> (!div3_raw && !div2_out));
endmodule

// File: tb/sim_div3_clock_divider.sv
module sim_div3_clock_divider;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div3_out, div3_raw, div2_out;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    div3_clock_divider u0 (
        .clk_in   (clk),
        .rst_n    (rst_n),
        .div3_out (div3_out),
        .div3_raw (div3_raw),
        .div2_out (div2_out)
    );

    always #10 clk = ~clk;

    // Reference model; h counts half-periods from the first rising edge after release.
    function automatic bit exp_main(int h); return (h % 6) < 3; endfunction
    function automatic bit exp_raw(int h);  return (h % 6) < 2; endfunction
    function automatic bit exp_half(int h); return ((h / 2) % 2) == 0; endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run(int hold, int nhalf);
        int last = -1;
        int rises = 0;
        bit prev = 1'b0;
        @(negedge clk); #2 rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #2;
            chk({div3_out, div3_raw, div2_out} == 3'b000, "R1", {div3_out, div3_raw, div2_out}, 0);
            @(negedge clk); #2;
            chk({div3_out, div3_raw, div2_out} == 3'b000, "R1", {div3_out, div3_raw, div2_out}, 0);
        end
        rst_n = 1'b1;
        for (int h = 0; h < nhalf; h++) begin
            if (h % 2 == 0) @(posedge clk); else @(negedge clk);
            #2;
            if (h == 0) chk(div3_out && div3_raw, "R6", {div3_out, div3_raw}, 3);
            chk(div3_out == exp_main(h), "R4/R5 R2 pattern", div3_out, exp_main(h));
            chk(div3_raw == exp_raw(h), "R3 R2 raw", div3_raw, exp_raw(h));
            chk(div2_out == exp_half(h), "R8", div2_out, exp_half(h));
            if (div3_out != prev) begin
                if (div3_out) begin
                    rises++;
                    chk(h % 2 == 0, "R4 rise on rising edge", h % 2, 0);
                    if (last >= 0 && h >= 6) chk(h - last == 3, "R5 low width", h - last, 3);
                end else begin
                    chk(h % 2 == 1, "R5 fall on falling edge", h % 2, 1);
                    if (last >= 0 && h >= 6) chk(h - last == 3, "R4 high width", h - last, 3);
                end
                last = h;
                prev = div3_out;
            end
        end
        chk(rises == (nhalf + 5) / 6, "R7 edge count", rises, (nhalf + 5) / 6);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 chk({div3_out, div3_raw, div2_out} == 3'b000, "R1 initial", {div3_out, div3_raw, div2_out}, 0);
        run(1, 20);
        run(4, 601);
        run(1, 7);
        for (int t = 0; t < 10; t++) begin
            run($urandom_range(1, 5), 6 * $urandom_range(2, 20) + $urandom_range(0, 5));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule